// File: doc/BRIEF.md
# Predicated Integer Execute Unit with Condition Flags

This block is the integer execute stage of a small 32-bit RISC pipeline. Each cycle it accepts one operation: a 5-bit operation code, two operands, a 3-bit predicate code, the destination register index and the current four-bit flag set. It decides whether the predicate lets the operation run. It then computes the result and a new flag set, and says whether that flag set may be committed.

It covers add, subtract, compare, test, AND, OR, XOR, three kinds of shift, bit reverse, the low-half merge, the three multiply words, move and immediate load. Any other operation code is reported as illegal. Division, floating point and memory access are handled by other units.

The result path is combinational. A parameter can add one register stage at the output, which moves every output one clock later.

Top module: `cond_exec_alu`

## Requirements
- R1: Operation codes select the result: 0 and 16 give A-B, 1 and 17 give A&B, 2 gives A+B, 3 gives A|B, 4 gives A^B, and 13, 24 and 25 pass B through.
- R2: `flags_out` is packed as Z in bit 0, C in bit 1, N in bit 2 and V in bit 3. When `flag_we` is high, Z is set exactly when the result is zero and N equals result bit 31. When `flag_we` is low, `flags_out` equals `flags_in`.
- R3: For subtract and compare, C is set when A < B as unsigned numbers. For add, C is the carry out of bit 31. For add, subtract, compare and the two logical shifts, V is result bit 31 XOR A bit 31. All other operations clear C and V unless R5 gives C.
- R4: Code 5 is a logical right shift, code 6 a left shift and code 7 an arithmetic right shift of A by the full 32-bit value of B. When B is 32 or more, the logical shifts give 0, and the arithmetic shift gives all ones for negative A and 0 otherwise.
- R5: Shift carry is 0 when B is 0. For codes 5 and 7 with 1 ≤ B ≤ 32, C is A bit B-1. For code 7 with B > 32, C is A bit 31. For code 6 with 1 ≤ B ≤ 32, C is A bit 32-B. For code 6 with B > 32, C is 0.
- R6: Code 8 returns B with bit i moved to bit 31-i. Code 9 returns {A[31:16], B[15:0]}.
- R7: Code 10 returns the upper word of the unsigned 64-bit product, code 11 the upper word of the signed product, and code 12 the lower word.
- R8: The predicate code selects: 0 always, 1 Z set, 2 N set, 3 C set, 4 V set, 5 Z clear, 6 N clear, 7 C clear, tested on `flags_in`. When the predicate fails, `out_valid` and `flag_we` stay low.
- R9: With a non-zero predicate, only compare (16) and test (17) may raise `flag_we`.
- R10: Codes 8, 9, 13, 24 and 25 never raise `flag_we`. Neither does a destination of 14 or 15, unless the operation is compare or test.
- R11: Codes 14, 15, 18 to 23 and 26 to 31 raise `illegal` whenever `in_valid` is high, whatever the predicate, and keep `out_valid` and `flag_we` low.
- R12: With the output register enabled, every output appears one clock after its inputs, and reset clears all outputs to 0.
- R13: `out_valid` is high exactly when `in_valid` is high, the code is legal and the predicate holds. `flag_we` is high exactly when `out_valid` is high and R9 and R10 allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code |
| cond | input | 3 | Predicate code |
| dst_reg | input | 4 | Destination register index |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B or immediate |
| flags_in | input | 4 | Current flags {V,N,C,Z} |
| out_valid | output | 1 | Operation executed with a legal code |
| result | output | 32 | Computed result |
| flags_out | output | 4 | New flags when `flag_we`, else `flags_in` |
| flag_we | output | 1 | Flags may be committed |
| illegal | output | 1 | Unsupported operation code |

## Verification
The bench builds two copies at a 32-bit width: `dut` with the output register enabled and `dut_comb` without it. Both copies receive the same stimulus. The registered copy covers the one-cycle delay and the cleared reset state. The combinational copy is compared in the same cycle the stimulus is applied, so the register cannot hide a fault in the result path. The 32-bit width makes the shift boundaries at 31, 32 and 33 and the sign of the 64-bit products reachable by directed vectors.

// File: rtl/cxalu_pkg.sv
package cxalu_pkg;

    typedef enum logic [4:0] {
        OP_SUB  = 5'd0,  OP_AND  = 5'd1,  OP_ADD  = 5'd2,  OP_OR   = 5'd3,
        OP_XOR  = 5'd4,  OP_LSR  = 5'd5,  OP_LSL  = 5'd6,  OP_ASR  = 5'd7,
        OP_BREV = 5'd8,  OP_LDLO = 5'd9,  OP_MPUH = 5'd10, OP_MPSH = 5'd11,
        OP_MPLO = 5'd12, OP_MOV  = 5'd13, OP_CMP  = 5'd16, OP_TST  = 5'd17,
        OP_LDI0 = 5'd24, OP_LDI1 = 5'd25
    } alu_op_e;

    // Packed so that z lands in bit 0 and v in bit 3
    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

    function automatic logic op_legal(input logic [4:0] op);
        return (op <= 5'd13) || (op == 5'd16) || (op == 5'd17) ||
               (op == 5'd24) || (op == 5'd25);
    endfunction

    function automatic logic op_compare(input logic [4:0] op);
        return (op == 5'd16) || (op == 5'd17);
    endfunction

    function automatic logic op_updates_flags(input logic [4:0] op);
        return !((op == 5'd8) || (op == 5'd9) || (op == 5'd13) ||
                 (op == 5'd24) || (op == 5'd25));
    endfunction

endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import cxalu_pkg::*;
(
    input  logic [2:0] cond,
    input  flags_t     flags,
    output logic       take
);
    always_comb begin
        case (cond)
            3'd0:    take = 1'b1;
            3'd1:    take = flags.z;
            3'd2:    take = flags.n;
            3'd3:    take = flags.c;
            3'd4:    take = flags.v;
            3'd5:    take = !flags.z;
            3'd6:    take = !flags.n;
            default: take = !flags.c;
        endcase
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import cxalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output flags_t            flags_new
);
    localparam int SHW  = $clog2(DATA_W);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] W_VAL = DATA_W'(DATA_W);
    localparam logic [SHW:0]      W_S   = (SHW+1)'(DATA_W);

    logic              big, b_zero, b_eq_w;
    logic [SHW-1:0]    sh;
    logic [SHW:0]      lsl_idx;
    logic [DATA_W:0]   sum;
    logic [2*DATA_W-1:0] prod_u, prod_s;
    logic [DATA_W-1:0] r_d, rev_d;
    logic              c_d, v_d, use_v;

    always_comb begin
        big     = (b >= W_VAL);
        b_zero  = (b == '0);
        b_eq_w  = (b == W_VAL);
        sh      = b[SHW-1:0];
        lsl_idx = W_S - {1'b0, sh};
        sum     = {1'b0, a} + {1'b0, b};
        prod_u  = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        prod_s  = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
        for (int i = 0; i < DATA_W; i++) begin
            rev_d[i] = b[DATA_W-1-i];
        end

        r_d   = '0;
        c_d   = 1'b0;
        use_v = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin
                r_d   = a - b;
                c_d   = (a < b);
                use_v = 1'b1;
            end
            OP_AND, OP_TST: r_d = a & b;
            OP_ADD: begin
                r_d   = sum[DATA_W-1:0];
                c_d   = sum[DATA_W];
                use_v = 1'b1;
            end
            OP_OR:  r_d = a | b;
            OP_XOR: r_d = a ^ b;
            OP_LSR: begin
                r_d   = big ? '0 : (a >> sh);
                use_v = 1'b1;
                if (b_zero)      c_d = 1'b0;
                else if (b_eq_w) c_d = a[DATA_W-1];
                else if (big)    c_d = 1'b0;
                else             c_d = a[sh - 1'b1];
            end
            OP_LSL: begin
                r_d   = big ? '0 : (a << sh);
                use_v = 1'b1;
                if (b_zero)      c_d = 1'b0;
                else if (b_eq_w) c_d = a[0];
                else if (big)    c_d = 1'b0;
                else             c_d = a[lsl_idx[SHW-1:0]];
            end
            OP_ASR: begin
                r_d = big ? {DATA_W{a[DATA_W-1]}}
                          : DATA_W'($signed(a) >>> sh);
                if (b_zero)   c_d = 1'b0;
                else if (big) c_d = a[DATA_W-1];
                else          c_d = a[sh - 1'b1];
            end
            OP_BREV: r_d = rev_d;
            OP_LDLO: r_d = {a[DATA_W-1:HALF], b[HALF-1:0]};
            OP_MPUH: r_d = prod_u[2*DATA_W-1:DATA_W];
            OP_MPSH: r_d = prod_s[2*DATA_W-1:DATA_W];
            OP_MPLO: r_d = prod_u[DATA_W-1:0];
            OP_MOV, OP_LDI0, OP_LDI1: r_d = b;
            default: r_d = '0;
        endcase

        v_d = use_v && (r_d[DATA_W-1] != a[DATA_W-1]);
        result      = r_d;
        flags_new.z = (r_d == '0);
        flags_new.n = r_d[DATA_W-1];
        flags_new.c = c_d;
        flags_new.v = v_d;
    end
endmodule

// File: rtl/alu_flag_policy.sv
module alu_flag_policy
    import cxalu_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int CC_REG = 14,
    parameter int PC_REG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [4:0]       op,
    input  logic [2:0]       cond,
    input  logic [REG_W-1:0] dst_reg,
    input  logic             take,
    output logic             res_valid,
    output logic             flag_we
);
    localparam logic [REG_W-1:0] CC_IDX = REG_W'(CC_REG);
    localparam logic [REG_W-1:0] PC_IDX = REG_W'(PC_REG);

    logic cmp, ctrl_dst;

    always_comb begin
        cmp       = op_compare(op);
        ctrl_dst  = (dst_reg == CC_IDX) || (dst_reg == PC_IDX);
        res_valid = in_valid && op_legal(op) && take;
        flag_we   = res_valid && op_updates_flags(op) &&
                    ((cond == 3'd0) || cmp) && (cmp || !ctrl_dst);
    end

    // R9
    pred_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond != 3'd0) && !op_compare(op)) |-> !flag_we);

    // R10
    ctrl_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((dst_reg == CC_IDX) || (dst_reg == PC_IDX)) && !op_compare(op)) |-> !flag_we);
endmodule

// File: rtl/cond_exec_alu.sv
module cond_exec_alu
    import cxalu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_W   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        opcode,
    input  logic [2:0]        cond,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              flag_we,
    output logic              illegal
);
    typedef struct packed {
        logic              out_valid;
        logic [DATA_W-1:0] result;
        flags_t            flags;
        logic              flag_we;
        logic              illegal;
    } stage_t;

    flags_t            fl_in;
    flags_t            fl_new;
    logic              take;
    logic              res_valid;
    logic              we;
    logic [DATA_W-1:0] dp_result;
    stage_t            stage_d, stage_q;

    assign fl_in = flags_t'(flags_in);

    alu_cond_eval u_cond (
        .cond  (cond),
        .flags (fl_in),
        .take  (take)
    );

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op        (opcode),
        .a         (op_a),
        .b         (op_b),
        .result    (dp_result),
        .flags_new (fl_new)
    );

    alu_flag_policy #(.REG_W(REG_W)) u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (opcode),
        .cond      (cond),
        .dst_reg   (dst_reg),
        .take      (take),
        .res_valid (res_valid),
        .flag_we   (we)
    );

    always_comb begin
        stage_d.out_valid = res_valid;
        stage_d.result    = dp_result;
        stage_d.flags     = we ? fl_new : fl_in;
        stage_d.flag_we   = we;
        stage_d.illegal   = in_valid && !op_legal(opcode);
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end

            // R12
            out_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> $past(stage_d.out_valid));
        end else begin : g_comb
            assign stage_q = stage_d;
        end
    endgenerate

    assign out_valid = stage_q.out_valid;
    assign result    = stage_q.result;
    assign flags_out = stage_q.flags;
    assign flag_we   = stage_q.flag_we;
    assign illegal   = stage_q.illegal;

    // R8
    cond_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !take) |-> (!stage_d.out_valid && !stage_d.flag_we));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_d.illegal |-> (!stage_d.out_valid && !stage_d.flag_we));

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_d.flag_we |-> (stage_d.flags == fl_in));
endmodule

// File: tb/tb_cond_exec_alu.sv
module tb_cond_exec_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [2:0]  cond = '0;
    logic [3:0]  dst_reg = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  flags_in = '0;

    logic        r_ov, c_ov, r_we, c_we, r_il, c_il;
    logic [31:0] r_res, c_res;
    logic [3:0]  r_fl, c_fl;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cond_exec_alu #(.DATA_W(32), .REG_W(4), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .cond(cond), .dst_reg(dst_reg), .op_a(op_a), .op_b(op_b),
        .flags_in(flags_in), .out_valid(r_ov), .result(r_res),
        .flags_out(r_fl), .flag_we(r_we), .illegal(r_il));

    cond_exec_alu #(.DATA_W(32), .REG_W(4), .OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .cond(cond), .dst_reg(dst_reg), .op_a(op_a), .op_b(op_b),
        .flags_in(flags_in), .out_valid(c_ov), .result(c_res),
        .flags_out(c_fl), .flag_we(c_we), .illegal(c_il));

    typedef struct {
        bit          ov;
        bit [31:0]   res;
        bit [3:0]    fl;
        bit          we;
        bit          il;
    } exp_t;

    function automatic exp_t model(bit iv, bit [4:0] op, bit [2:0] cd,
                                   bit [3:0] dst, bit [31:0] a, bit [31:0] b,
                                   bit [3:0] fin);
        exp_t e;
        bit legal, cmp, take, wr, c, v;
        bit [31:0] r;
        bit [32:0] s;
        longint sa, sb;
        bit [63:0] pu, ps;
        legal = (op <= 13) || op == 16 || op == 17 || op == 24 || op == 25;
        cmp = (op == 16) || (op == 17);
        case (cd)
            0: take = 1; 1: take = fin[0]; 2: take = fin[2]; 3: take = fin[1];
            4: take = fin[3]; 5: take = !fin[0]; 6: take = !fin[2];
            default: take = !fin[1];
        endcase
        r = 0; c = 0; v = 0;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        pu = {32'd0, a} * {32'd0, b};
        ps = 64'(sa * sb);
        case (op)
            0, 16: begin r = a - b; c = a < b; v = r[31] ^ a[31]; end
            1, 17: r = a & b;
            2: begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32]; v = r[31] ^ a[31]; end
            3: r = a | b;
            4: r = a ^ b;
            5: begin r = (b >= 32) ? 0 : a >> b; v = r[31] ^ a[31];
                     c = (b >= 1 && b <= 32) ? a[b-1] : 0; end
            6: begin r = (b >= 32) ? 0 : a << b; v = r[31] ^ a[31];
                     c = (b >= 1 && b <= 32) ? a[32-b] : 0; end
            7: begin r = (b >= 32) ? {32{a[31]}} : 32'($signed(a) >>> b[4:0]);
                     c = (b == 0) ? 0 : (b <= 32) ? a[b-1] : a[31]; end
            8: for (int i = 0; i < 32; i++) r[i] = b[31-i];
            9: r = {a[31:16], b[15:0]};
            10: r = pu[63:32];
            11: r = ps[63:32];
            12: r = pu[31:0];
            13, 24, 25: r = b;
            default: r = 0;
        endcase
        wr = !(op == 8 || op == 9 || op == 13 || op == 24 || op == 25);
        e.ov = iv && legal && take;
        e.we = e.ov && wr && (cd == 0 || cmp) && (cmp || dst < 14);
        e.il = iv && !legal;
        e.res = r;
        e.fl = e.we ? {v, r[31], c, (r == 0)} : fin;
        return e;
    endfunction

    function automatic string tag_of(bit iv, bit [4:0] op, bit [2:0] cd, bit [3:0] fin, bit [3:0] dst);
        exp_t e;
        e = model(iv, op, cd, dst, 32'd0, 32'd0, fin);
        if (iv && !((op <= 13) || op == 16 || op == 17 || op == 24 || op == 25)) return "R11";
        if (!e.ov) return "R8";
        if (cd != 0) return "R9";
        if (dst >= 14) return "R10";
        case (op)
            0, 2, 16: return "R3";
            5, 6, 7: return "R4";
            8, 9: return "R6";
            10, 11, 12: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic cmp_out(string tag, string who, exp_t e, logic ov, logic [31:0] r,
                           logic [3:0] f, logic we, logic il);
        bit bad;
        checks++;
        bad = (ov !== e.ov) || (we !== e.we) || (il !== e.il) || (f !== e.fl) ||
              (e.ov && (r !== e.res));
        if (bad) begin
            fails++;
            $display("FAIL %s %s: got ov=%0b res=%h fl=%h we=%0b il=%0b exp ov=%0b res=%h fl=%h we=%0b il=%0b",
                     tag, who, ov, r, f, we, il, e.ov, e.res, e.fl, e.we, e.il);
        end
    endtask

    exp_t prev;
    bit   prev_ok = 1'b0;

    // Drive at negedge, check comb copy, check that the registered copy still holds
    // the previous result (R12), then check it after the next rising edge.
    task automatic run_vec(string tag, bit iv, bit [4:0] op, bit [2:0] cd, bit [3:0] dst,
                           bit [31:0] a, bit [31:0] b, bit [3:0] fin);
        exp_t e;
        e = model(iv, op, cd, dst, a, b, fin);
        in_valid = iv; opcode = op; cond = cd; dst_reg = dst;
        op_a = a; op_b = b; flags_in = fin;
        #1;
        cmp_out(tag, "comb", e, c_ov, c_res, c_fl, c_we, c_il);
        if (prev_ok) cmp_out("R12", "hold", prev, r_ov, r_res, r_fl, r_we, r_il);
        @(posedge clk); #1;
        cmp_out(tag, "reg", e, r_ov, r_res, r_fl, r_we, r_il);
        prev = e; prev_ok = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if ({r_ov, r_res, r_fl, r_we, r_il} !== '0) begin
            fails++;
            $display("FAIL R12 reset: got ov=%0b res=%h fl=%h we=%0b il=%0b exp all 0",
                     r_ov, r_res, r_fl, r_we, r_il);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_vec("R2",  1, 0,  0, 1, 32'h5, 32'h5, 4'h0);               // zero result sets Z
        run_vec("R3",  1, 0,  0, 1, 32'h1, 32'h2, 4'h0);               // borrow
        run_vec("R3",  1, 2,  0, 1, 32'hFFFF_FFFF, 32'h1, 4'h0);       // carry out
        run_vec("R3",  1, 2,  0, 1, 32'h7FFF_FFFF, 32'h1, 4'h0);       // sign change
        run_vec("R4",  1, 5,  0, 1, 32'h8000_0001, 32'd32, 4'h0);
        run_vec("R4",  1, 6,  0, 1, 32'h8000_0001, 32'd33, 4'h0);
        run_vec("R4",  1, 7,  0, 1, 32'h8000_0000, 32'd40, 4'h0);
        run_vec("R4",  1, 7,  0, 1, 32'h7000_0000, 32'h1_0000, 4'h0);
        run_vec("R5",  1, 5,  0, 1, 32'h8000_0000, 32'd32, 4'h0);
        run_vec("R5",  1, 6,  0, 1, 32'h0000_0001, 32'd32, 4'h0);
        run_vec("R5",  1, 6,  0, 1, 32'h4000_0000, 32'd2, 4'h0);
        run_vec("R5",  1, 7,  0, 1, 32'h8000_0000, 32'd33, 4'h0);
        run_vec("R5",  1, 5,  0, 1, 32'hFFFF_FFFF, 32'd0, 4'h0);
        run_vec("R6",  1, 8,  0, 1, 32'h0, 32'h0000_0001, 4'h0);
        run_vec("R6",  1, 9,  0, 1, 32'hABCD_1234, 32'h5678_9ABC, 4'h0);
        run_vec("R7",  1, 11, 0, 1, 32'hFFFF_FFFE, 32'h0000_0003, 4'h0);
        run_vec("R7",  1, 10, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0);
        run_vec("R7",  1, 12, 0, 1, 32'h0001_0000, 32'h0001_0000, 4'h0);
        run_vec("R1",  1, 24, 0, 1, 32'h1, 32'h0, 4'hF);
        run_vec("R8",  1, 2,  1, 1, 32'h1, 32'h1, 4'h0);               // Z clear: skip
        run_vec("R8",  1, 2,  7, 1, 32'h1, 32'h1, 4'h2);               // C set: skip
        run_vec("R9",  1, 2,  4, 1, 32'h1, 32'h1, 4'h8);               // runs, no flags
        run_vec("R9",  1, 16, 6, 1, 32'h1, 32'h2, 4'h0);               // compare writes
        run_vec("R10", 1, 2,  0, 15, 32'h1, 32'h1, 4'h0);
        run_vec("R10", 1, 17, 0, 14, 32'h0, 32'h1, 4'h0);
        run_vec("R11", 1, 14, 1, 1, 32'h1, 32'h1, 4'h0);
        run_vec("R11", 1, 20, 0, 1, 32'h1, 32'h1, 4'h0);
        run_vec("R13", 0, 2,  0, 1, 32'h1, 32'h1, 4'h0);

        // Constrained random
        for (int k = 0; k < 3000; k++) begin
            bit iv; bit [4:0] op; bit [2:0] cd; bit [3:0] dst, fin;
            bit [31:0] a, b;
            iv  = ($urandom_range(0, 9) != 0);
            op  = ($urandom_range(0, 4) == 0) ? 5'($urandom_range(0, 31))
                : ($urandom_range(0, 3) == 0) ? 5'($urandom_range(16, 17) + (($urandom_range(0,1)) ? 8 : 0))
                : 5'($urandom_range(0, 13));
            cd  = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
            dst = 4'($urandom);
            fin = 4'($urandom);
            a   = $urandom;
            b   = ($urandom_range(0, 2) == 0) ? 32'($urandom_range(0, 40)) : $urandom;
            if ($urandom_range(0, 9) == 0) b = a;
            run_vec(tag_of(iv, op, cd, fin, dst), iv, op, cd, dst, a, b, fin);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule